// File: doc/BRIEF.md
# Packed Double to Int32 Truncating Converter

This block takes a 128-bit vector holding two IEEE-754 double-precision numbers and turns each into a signed 32-bit integer. Each result is rounded toward zero, whatever rounding mode the rest of the machine uses. Lane 0 is taken from source bits 63:0 and its result goes to destination bits 31:0. Lane 1 is taken from source bits 127:64 and its result goes to destination bits 63:32. Destination bits 127:64 are always zero.

For each operation the block reports two status flags, Invalid and Precision, ORed over both lanes. Two mask inputs come with the operand. When an exception that is not masked occurs, the block raises a separate exception output and drops the destination write enable, so the surrounding logic can pick the fault to deliver.

Operands enter through a valid/ready handshake. Results leave through another one, after a fixed pipeline latency of two cycles. A stall at the output holds the whole pipeline.

Top module: `packed_trunc_cvt`

## Requirements
- R1: Lane 0 (source bits 63:0) gives destination bits 31:0, lane 1 (source bits 127:64) gives destination bits 63:32, and destination bits 127:64 are zero.
- R2: A finite input whose truncated value lies in -2^31..2^31-1 produces that value rounded toward zero, in two's complement.
- R3: A NaN, an infinity, or a finite value whose truncation lies outside -2^31..2^31-1 sets Invalid and produces 0x80000000 in that lane.
- R4: Any input in the range (-2^31-1, -2^31] produces 0x80000000 with no Invalid. Precision is set if a fraction was dropped.
- R5: Precision is set when nonzero fraction bits are discarded in a lane that did not raise Invalid. Denormals convert to 0 with Precision set. Both +0 and -0 convert to 0 with no flag.
- R6: statusInv and statusPe are the OR of the per-lane flags of one operation.
- R7: A mask bit of 1 suppresses its exception. If Invalid occurs with maskInv=0, or Precision occurs with maskPe=0, then excOut=1 and dstWe=0. Otherwise excOut=0 and dstWe=1.
- R8: An operand accepted on a clock edge appears with oValid=1 two edges later. inReady equals !oValid || oReady.
- R9: While oValid=1 and oReady=0, oValid and all result outputs hold their values.
- R10: After reset oValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand valid |
| inReady | output | 1 | Block can accept an operand |
| srcVec | input | 128 | Two packed doubles |
| maskInv | input | 1 | 1 masks the Invalid exception |
| maskPe | input | 1 | 1 masks the Precision exception |
| oValid | output | 1 | Result valid |
| oReady | input | 1 | Consumer accepts the result |
| dstVec | output | 128 | Two packed int32 results, upper half zero |
| dstWe | output | 1 | Destination may be written |
| statusInv | output | 1 | Invalid occurred in some lane |
| statusPe | output | 1 | Precision occurred in some lane |
| excOut | output | 1 | An unmasked exception occurred |

## Verification
The bench builds the block with its default values: two lanes, 32-bit integers and a 128-bit vector. At these values every boundary of the 32-bit result range can be reached directly: exactly ±2^31, ±(2^31-0.5), -(2^31+0.5), NaN, the infinities, denormals and signed zeros. The two-lane width also lets the bench put a faulting value next to a clean one, which shows the flags being ORed across lanes and the results staying separate. A reference model in the bench, based on real arithmetic, gives the expected values, and every combination of mask bits is applied.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int DBL_W  = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int BIAS   = 1023;
  localparam int INT_W  = 32;

  typedef struct packed {
    logic ld1;
    logic ld2;
  } strobe_t;

  typedef struct packed {
    logic [INT_W-1:0] val;
    logic             inv;
    logic             pe;
  } lane_res_t;
endpackage

// File: rtl/cvt_lane.sv
module cvt_lane
  import cvt_pkg::*;
(
  input  logic [DBL_W-1:0] src,
  output lane_res_t        res
);
  localparam int MW   = FRAC_W + 1;
  localparam int SH_W = $clog2(MW + 1);
  localparam logic [INT_W-1:0] MIN_INT = {1'b1, {(INT_W-1){1'b0}}};

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [MW-1:0]     mant, shifted, lostMask;
  logic [EXP_W-1:0]  k;
  logic [SH_W-1:0]   shamt;
  logic [INT_W-1:0]  mag;

  always_comb begin
    sgn      = src[DBL_W-1];
    ex       = src[DBL_W-2 -: EXP_W];
    fr       = src[FRAC_W-1:0];
    mant     = {1'b1, fr};
    k        = ex - EXP_W'(BIAS);
    shamt    = SH_W'(FRAC_W) - SH_W'(k);
    shifted  = mant >> shamt;
    lostMask = (MW'(1) << shamt) - MW'(1);
    mag      = shifted[INT_W-1:0];
    res.val  = '0;
    res.inv  = 1'b0;
    res.pe   = 1'b0;
    if (ex == {EXP_W{1'b1}}) begin
      res.inv = 1'b1;
      res.val = MIN_INT;
    end else if (ex < EXP_W'(BIAS)) begin
      res.pe = |src[DBL_W-2:0];
    end else if (k < EXP_W'(INT_W-1)) begin
      res.pe  = |(mant & lostMask);
      res.val = sgn ? (~mag + INT_W'(1)) : mag;
    end else if (k == EXP_W'(INT_W-1) && sgn &&
                 fr[FRAC_W-1 -: INT_W-1] == '0) begin
      res.val = MIN_INT;
      res.pe  = |fr[FRAC_W-INT_W:0];
    end else begin
      res.inv = 1'b1;
      res.val = MIN_INT;
    end
  end
endmodule

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    oReady,
  output logic    inReady,
  output logic    oValid,
  output strobe_t strobe
);
  logic s1Valid, outValid, adv;

  assign adv          = !outValid || oReady;
  assign inReady      = adv;
  assign oValid       = outValid;
  assign strobe.ld1   = adv && inValid;
  assign strobe.ld2   = adv && s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else if (adv) begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !oReady) |=> outValid);
  a_r8_two_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && adv) |=> outValid);
endmodule

// File: rtl/cvt_datapath.sv
module cvt_datapath
  import cvt_pkg::*;
#(
  parameter int LANES = 2,
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [VEC_W-1:0] srcVec,
  input  logic             maskInv,
  input  logic             maskPe,
  input  logic             oReady,
  input  logic             oValid,
  output logic [VEC_W-1:0] dstVec,
  output logic             dstWe,
  output logic             statusInv,
  output logic             statusPe,
  output logic             excOut
);
  localparam int RES_W = LANES * INT_W;
  localparam logic [INT_W-1:0] MIN_INT = {1'b1, {(INT_W-1){1'b0}}};

  lane_res_t laneRes [LANES];
  lane_res_t s1Res   [LANES];
  logic      s1MaskInv, s1MaskPe;
  logic [LANES-1:0] invBits, peBits;
  logic [RES_W-1:0] packed_;
  logic invAny, peAny, excNext;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    cvt_lane u_lane (.src(srcVec[i*DBL_W +: DBL_W]), .res(laneRes[i]));

    always_ff @(posedge clk) begin
      if (!rstN)           s1Res[i] <= '0;
      else if (strobe.ld1) s1Res[i] <= laneRes[i];
    end

    assign invBits[i] = s1Res[i].inv;
    assign peBits[i]  = s1Res[i].pe;
    assign packed_[i*INT_W +: INT_W] = s1Res[i].val;

    a_r3_invalid_code: assert property (@(posedge clk) disable iff (!rstN)
      s1Res[i].inv |-> s1Res[i].val == MIN_INT);
    a_r5_flag_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      !(s1Res[i].inv && s1Res[i].pe));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1MaskInv <= 1'b1;
      s1MaskPe  <= 1'b1;
    end else if (strobe.ld1) begin
      s1MaskInv <= maskInv;
      s1MaskPe  <= maskPe;
    end
  end

  assign invAny  = |invBits;
  assign peAny   = |peBits;
  assign excNext = (invAny && !s1MaskInv) || (peAny && !s1MaskPe);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstVec    <= '0;
      dstWe     <= 1'b0;
      statusInv <= 1'b0;
      statusPe  <= 1'b0;
      excOut    <= 1'b0;
    end else if (strobe.ld2) begin
      dstVec    <= {{(VEC_W-RES_W){1'b0}}, packed_};
      statusInv <= invAny;
      statusPe  <= peAny;
      excOut    <= excNext;
      dstWe     <= !excNext;
    end
  end

  a_r9_result_stable: assert property (@(posedge clk) disable iff (!rstN)
    (oValid && !oReady) |=> ($stable(dstVec) && $stable(excOut) && $stable(dstWe)));
  a_r7_exc_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    (oValid && excOut) |-> (statusInv || statusPe));
endmodule

// File: rtl/packed_trunc_cvt.sv
module packed_trunc_cvt
  import cvt_pkg::*;
#(
  parameter int LANES = 2,
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [VEC_W-1:0] srcVec,
  input  logic             maskInv,
  input  logic             maskPe,
  output logic             oValid,
  input  logic             oReady,
  output logic [VEC_W-1:0] dstVec,
  output logic             dstWe,
  output logic             statusInv,
  output logic             statusPe,
  output logic             excOut
);
  strobe_t strobe;

  cvt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .oReady(oReady),
    .inReady(inReady), .oValid(oValid), .strobe(strobe)
  );

  cvt_datapath #(.LANES(LANES), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcVec(srcVec),
    .maskInv(maskInv), .maskPe(maskPe), .oReady(oReady), .oValid(oValid),
    .dstVec(dstVec), .dstWe(dstWe), .statusInv(statusInv),
    .statusPe(statusPe), .excOut(excOut)
  );

  a_r10_ready_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !oValid |-> inReady);
endmodule

// File: tb/tb_packed_trunc_cvt.sv
module tb_packed_trunc_cvt;
  logic clk = 0, rstN = 0, inValid = 0, oReady = 1, maskInv = 1, maskPe = 1;
  logic [127:0] srcVec = '0;
  logic inReady, oValid, dstWe, statusInv, statusPe, excOut;
  logic [127:0] dstVec;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  packed_trunc_cvt dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic refConv(input logic [63:0] d, output logic [31:0] r,
                         output bit inv, output bit pe);
    real x;
    int ti;
    inv = 0; pe = 0; r = 32'h8000_0000;
    if (d[62:52] == 11'h7FF) begin inv = 1; return; end
    x = $bitstoreal(d);
    if (x >= 2147483648.0 || x <= -2147483649.0) begin inv = 1; return; end
    ti = $rtoi(x);
    r  = ti;
    pe = ($itor(ti) != x);
  endtask

  // Converts one operand and checks R1-R8 against the reference model.
  task automatic tConvert(input string name, input logic [63:0] a,
                          input logic [63:0] b, input bit mi, input bit mp);
    logic [31:0] r0, r1;
    bit i0, p0, i1, p1, eInv, ePe, eExc;
    refConv(a, r0, i0, p0);
    refConv(b, r1, i1, p1);
    eInv = i0 | i1; ePe = p0 | p1;
    eExc = (eInv && !mi) || (ePe && !mp);
    @(negedge clk);
    srcVec = {b, a}; maskInv = mi; maskPe = mp; inValid = 1; oReady = 1;
    @(negedge clk);
    inValid = 0;
    chk(oValid == 0, "R8", {name, " early valid"}, oValid, 0);
    @(negedge clk);
    chk(oValid == 1, "R8", {name, " valid at 2"}, oValid, 1);
    chk(statusInv == eInv, "R6", {name, " inv"}, statusInv, eInv);
    chk(statusPe == ePe, "R6", {name, " pe"}, statusPe, ePe);
    chk(excOut == eExc, "R7", {name, " exc"}, excOut, eExc);
    chk(dstWe == !eExc, "R7", {name, " we"}, dstWe, !eExc);
    chk(dstVec[127:64] == 0, "R1", {name, " upper"}, dstVec[127:64], 0);
    chk(dstVec[31:0] == r0, "R2", {name, " lane0"}, dstVec[31:0], r0);
    chk(dstVec[63:32] == r1, "R3", {name, " lane1"}, dstVec[63:32], r1);
  endtask

  task automatic tReset();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    chk(oValid == 0, "R10", "oValid after reset", oValid, 0);
    chk(inReady == 1, "R10", "inReady after reset", inReady, 1);
  endtask

  task automatic tStall();
    logic [127:0] held;
    @(negedge clk);
    srcVec = {$realtobits(-7.9), $realtobits(3.25)}; maskInv = 1; maskPe = 1;
    inValid = 1; oReady = 0;
    @(negedge clk) inValid = 0;
    @(negedge clk);
    held = dstVec;
    chk(oValid == 1, "R9", "stall valid", oValid, 1);
    chk(inReady == 0, "R8", "stall not ready", inReady, 0);
    repeat (4) @(negedge clk);
    chk(oValid == 1, "R9", "stall hold valid", oValid, 1);
    chk(dstVec == held, "R9", "stall hold data", dstVec, held);
    chk(dstVec[63:0] == 64'hFFFF_FFF9_0000_0003, "R2", "stall values",
        dstVec[63:0], 64'hFFFF_FFF9_0000_0003);
    oReady = 1;
    @(negedge clk);
    chk(oValid == 0, "R8", "drained", oValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tReset();
    tConvert("basic", $realtobits(1.5), $realtobits(-2.75), 1, 1);
    tConvert("big", $realtobits(123456.99), $realtobits(-0.3), 1, 1);
    tConvert("exact", $realtobits(42.0), $realtobits(-1000.0), 0, 0);
    tConvert("pos2p31", 64'h41E0_0000_0000_0000, 64'h41DF_FFFF_FFE0_0000, 1, 1);
    tConvert("neg2p31", 64'hC1E0_0000_0000_0000, 64'hC1DF_FFFF_FFE0_0000, 1, 1); // R4
    tConvert("neg2p31h", 64'hC1E0_0000_0010_0000, $realtobits(0.0), 1, 1);       // R4
    tConvert("nan_inf", 64'h7FF8_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1, 1);
    tConvert("posinf", 64'h7FF0_0000_0000_0000, 64'hC1F0_0000_0000_0000, 1, 1);
    tConvert("denorm", 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 1, 1);  // R5
    tConvert("negdenorm", 64'h800F_FFFF_FFFF_FFFF, 64'h0, 1, 1);                  // R5
    tConvert("unmaskInv", 64'h7FF8_0000_0000_0000, $realtobits(2.0), 0, 1);       // R7
    tConvert("maskedInv", 64'h7FF8_0000_0000_0000, $realtobits(2.0), 1, 0);       // R7
    tConvert("unmaskPe", $realtobits(2.5), $realtobits(3.0), 1, 0);               // R7
    tConvert("maskPe", $realtobits(2.5), $realtobits(3.0), 0, 1);                 // R7
    tStall();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule